// File: doc/BRIEF.md
# Alarm Interrupt Summary and Reset Controller

This block gathers alarm activity for a multi-port line device and turns it into a single interrupt. There are six alarm sources: an A-side bus, a B-side bus and four ports. Each source has its own group of alarm level inputs and its own mask bit. When a source's mask bit is set and any alarm in its group is active, the source shows in an 8-bit summary register. A separate software interrupt bit is driven by edge events on eight monitored alarm lines. Each line has its own 2-bit polarity selection, and the events are held in a latch that is cleared when the summary is read. The interrupt pin is active low and is asserted whenever the summary register is non-zero.

A command register launches self-timed reset cycles toward the rest of the chip. There is a whole-device reset, and there is an alarm clear for each bus side. Each reset bit reads back as 1 while its cycle runs and returns to 0 when the cycle ends. The whole-device reset also clears the block's own configuration, except for the two bus high-impedance controls. It also issues a one-cycle FIFO re-center strobe. Software uses a simple synchronous bus: writes take effect on the clock edge that samples them, and read data is registered.

Top module: `alarm_irq_ctrl`

## Requirements
- R1: Reading address 0 returns the summary register one cycle after the read strobe. The bit layout is: bit 7 software interrupt, bit 6 always 0, bit 5 A side, bit 4 B side, bits 3..0 ports 4..1. Alarm group s sits in `alarm_lvl_i[s*ALM_PER_SRC +: ALM_PER_SRC]`, where s=0..3 are ports 1..4, s=4 is B and s=5 is A. Source bit s is 1 exactly when mask bit s is 1 and any alarm in group s is 1.
- R2: The mask register is at address 1 and uses the same bit positions as the summary. Bit 6 always reads 0.
- R3: The polarity code for monitored line k sits in bits [2*(k%4)+1 : 2*(k%4)] of address 4 (k=0..3) or address 5 (k=4..7). The codes are: 00 no event, 01 rising edge, 10 falling edge, 11 both edges. An event sets the software interrupt latch only while mask bit 7 is 1.
- R4: A summary read clears the software interrupt latch. If an event occurs on the same edge as the read, the latch stays set.
- R5: `irq_n_o` is a register. It is low on the cycle after the summary register is non-zero, and high on the cycle after it is zero.
- R6: The command register is at address 2: bit 7 global reset, bit 6 A-side alarm clear, bit 5 B-side alarm clear. Writing 1 to one of these bits starts a reset cycle of RST_CYCLES (8) clocks. During the cycle the bit reads 1 and its strobe output is high. Bits 4..0 have no effect and read 0.
- R7: A global reset clears the mask register, both polarity registers, control bits 5..0 (address 3) and the software interrupt latch. It keeps control bits 7 (A high-impedance) and 6 (B high-impedance). Writes to the mask, control and polarity registers are ignored while it runs.
- R8: An A-side cycle raises `alm_clr_a_o` only, and a B-side cycle raises `alm_clr_b_o` only. A global cycle raises `glb_rst_o` and both side clears.
- R9: `fifo_recenter_o` is high for exactly the first cycle of a global reset cycle.
- R10: Writing a reset bit again while its cycle is running neither extends nor restarts that cycle.
- R11: After the synchronous reset input, all registers read 0, `irq_n_o` is 1 and every strobe and control output is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous active-high reset |
| wr_en_i | input | 1 | Register write strobe |
| rd_en_i | input | 1 | Register read strobe |
| addr_i | input | 3 | Register address |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Registered read data |
| alarm_lvl_i | input | 6*ALM_PER_SRC | Alarm levels, one group per source |
| trans_lvl_i | input | 8 | Monitored alarm lines for edge events |
| irq_n_o | output | 1 | Active-low interrupt |
| glb_rst_o | output | 1 | Global reset strobe |
| alm_clr_a_o | output | 1 | A-side alarm clear strobe |
| alm_clr_b_o | output | 1 | B-side alarm clear strobe |
| fifo_recenter_o | output | 1 | One-cycle FIFO re-center pulse |
| hiz_a_o | output | 1 | A bus high-impedance control |
| hiz_b_o | output | 1 | B bus high-impedance control |
| ctrl_o | output | 6 | General control bits |

## Verification
Each result has a fixed due cycle:

- A register write takes effect on the edge that samples it, and read data appears after the next edge.
- A change on an alarm level moves the source bit at once, and `irq_n_o` follows one edge later.
- An edge on a monitored line is registered in the latch on the edge that sees it, so the summary shows it right away, and the interrupt pin follows one edge after that.
- A reset strobe rises on the command-write edge and falls RST_CYCLES edges later.

The bench drives every input on the falling clock edge and samples on a later falling edge. It counts exactly the number of rising edges given above before comparing. Strobe lengths are measured by sampling once per cycle from the first falling edge after the command write.

// File: rtl/alarm_irq_pkg.sv
package alarm_irq_pkg;

    localparam int REG_W      = 8;
    localparam int ADDR_W     = 3;
    localparam int NUM_SRC    = 6;
    localparam int NUM_TRANS  = 8;
    localparam int POL_W      = 2 * NUM_TRANS;
    localparam int GEN_CTRL_W = 6;

    localparam int SUM_SWI_BIT  = 7;
    localparam int SUM_RSVD_BIT = 6;

    localparam int NUM_RST_CH = 3;
    localparam int RST_CH_GLB = 0;
    localparam int RST_CH_A   = 1;
    localparam int RST_CH_B   = 2;

    typedef enum logic [ADDR_W-1:0] {
        ADDR_SUM    = 3'd0,
        ADDR_MASK   = 3'd1,
        ADDR_CMD    = 3'd2,
        ADDR_CTRL   = 3'd3,
        ADDR_POL_LO = 3'd4,
        ADDR_POL_HI = 3'd5
    } reg_addr_e;

    typedef enum logic [1:0] {
        POL_OFF  = 2'b00,
        POL_RISE = 2'b01,
        POL_FALL = 2'b10,
        POL_BOTH = 2'b11
    } edge_pol_e;

    typedef struct packed {
        logic                  hiz_a;
        logic                  hiz_b;
        logic [GEN_CTRL_W-1:0] gen;
    } ctrl_reg_t;

    typedef struct packed {
        logic               swi;
        logic               rsvd;
        logic [NUM_SRC-1:0] src;
    } sum_reg_t;

    // Command bit owned by reset channel ch: global 7, A 6, B 5.
    function automatic int cmd_bit(input int ch);
        return REG_W - 1 - ch;
    endfunction

    function automatic logic edge_hit(input logic [1:0] pol, input logic cur, input logic prev);
        logic rise_sel;
        logic fall_sel;
        rise_sel = (pol == POL_RISE) || (pol == POL_BOTH);
        fall_sel = (pol == POL_FALL) || (pol == POL_BOTH);
        return (rise_sel & cur & ~prev) | (fall_sel & ~cur & prev);
    endfunction

endpackage

// File: rtl/alarm_src_summary.sv
module alarm_src_summary
    import alarm_irq_pkg::*;
#(
    parameter int ALM_PER_SRC = 4,
    localparam int ALM_W = NUM_SRC * ALM_PER_SRC
) (
    input  logic [ALM_W-1:0]   alarm_lvl_i,
    input  logic [NUM_SRC-1:0] mask_i,
    output logic [NUM_SRC-1:0] ind_o
);

    for (genvar s = 0; s < NUM_SRC; s++) begin : g_src
        logic any_active;
        assign any_active = |alarm_lvl_i[s*ALM_PER_SRC +: ALM_PER_SRC];
        assign ind_o[s]   = mask_i[s] & any_active;
    end

endmodule

// File: rtl/alarm_trans_latch.sv
module alarm_trans_latch
    import alarm_irq_pkg::*;
(
    input  logic                 clk_i,
    input  logic                 rst_i,
    input  logic [POL_W-1:0]     pol_i,
    input  logic [NUM_TRANS-1:0] lvl_i,
    input  logic                 arm_i,
    input  logic                 rd_clr_i,
    input  logic                 hold_clr_i,
    output logic                 latch_o
);

    logic [NUM_TRANS-1:0] prev_q;
    logic [NUM_TRANS-1:0] hit;
    logic                 latch_q;

    for (genvar k = 0; k < NUM_TRANS; k++) begin : g_line
        assign hit[k] = edge_hit(pol_i[2*k +: 2], lvl_i[k], prev_q[k]);
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            prev_q <= '0;
        end else begin
            prev_q <= lvl_i;
        end
    end

    always_ff @(posedge clk_i) begin
        if (rst_i || hold_clr_i) begin
            latch_q <= 1'b0;
        end else if ((|hit) && arm_i) begin
            latch_q <= 1'b1;
        end else if (rd_clr_i) begin
            latch_q <= 1'b0;
        end
    end

    assign latch_o = latch_q;

endmodule

// File: rtl/alarm_rst_seq.sv
module alarm_rst_seq #(
    parameter int RST_CYCLES = 8,
    localparam int CNT_W = (RST_CYCLES > 1) ? $clog2(RST_CYCLES) : 1
) (
    input  logic clk_i,
    input  logic rst_i,
    input  logic start_i,
    output logic busy_o
);

    logic [CNT_W-1:0] cnt_q;
    logic             busy_q;

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            busy_q <= 1'b0;
            cnt_q  <= '0;
        end else if (busy_q) begin
            if (cnt_q == '0) begin
                busy_q <= 1'b0;
            end else begin
                cnt_q <= cnt_q - 1'b1;
            end
        end else if (start_i) begin
            busy_q <= 1'b1;
            cnt_q  <= CNT_W'(RST_CYCLES - 1);
        end
    end

    assign busy_o = busy_q;

endmodule

// File: rtl/alarm_irq_ctrl.sv
module alarm_irq_ctrl
    import alarm_irq_pkg::*;
#(
    parameter int ALM_PER_SRC = 4,
    parameter int RST_CYCLES  = 8,
    localparam int ALM_W = NUM_SRC * ALM_PER_SRC
) (
    input  logic                  clk_i,
    input  logic                  rst_i,
    input  logic                  wr_en_i,
    input  logic                  rd_en_i,
    input  logic [ADDR_W-1:0]     addr_i,
    input  logic [REG_W-1:0]      wdata_i,
    output logic [REG_W-1:0]      rdata_o,
    input  logic [ALM_W-1:0]      alarm_lvl_i,
    input  logic [NUM_TRANS-1:0]  trans_lvl_i,
    output logic                  irq_n_o,
    output logic                  glb_rst_o,
    output logic                  alm_clr_a_o,
    output logic                  alm_clr_b_o,
    output logic                  fifo_recenter_o,
    output logic                  hiz_a_o,
    output logic                  hiz_b_o,
    output logic [GEN_CTRL_W-1:0] ctrl_o
);

    reg_addr_e addr_e;
    assign addr_e = reg_addr_e'(addr_i);

    // Register state
    logic [REG_W-1:0] mask_q;
    ctrl_reg_t        ctrl_q;
    logic [POL_W-1:0] pol_q;
    logic [REG_W-1:0] rdata_q;
    logic             irq_n_q;
    logic             recenter_q;

    // Reset sequencers
    logic [NUM_RST_CH-1:0] rst_start;
    logic [NUM_RST_CH-1:0] rst_busy;
    logic                  cmd_wr;
    logic                  glb_clr;

    assign cmd_wr = wr_en_i && (addr_e == ADDR_CMD);

    for (genvar c = 0; c < NUM_RST_CH; c++) begin : g_rst
        assign rst_start[c] = cmd_wr && wdata_i[cmd_bit(c)] && !rst_busy[c];
        alarm_rst_seq #(.RST_CYCLES(RST_CYCLES)) u_seq (
            .clk_i   (clk_i),
            .rst_i   (rst_i),
            .start_i (rst_start[c]),
            .busy_o  (rst_busy[c])
        );
    end

    assign glb_clr = rst_start[RST_CH_GLB] || rst_busy[RST_CH_GLB];

    // Configuration registers
    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            mask_q <= '0;
            ctrl_q <= '0;
            pol_q  <= '0;
        end else if (glb_clr) begin
            mask_q     <= '0;
            ctrl_q.gen <= '0;
            pol_q      <= '0;
        end else if (wr_en_i) begin
            case (addr_e)
                ADDR_MASK: begin
                    mask_q               <= wdata_i;
                    mask_q[SUM_RSVD_BIT] <= 1'b0;
                end
                ADDR_CTRL:   ctrl_q                 <= ctrl_reg_t'(wdata_i);
                ADDR_POL_LO: pol_q[REG_W-1:0]       <= wdata_i;
                ADDR_POL_HI: pol_q[POL_W-1:REG_W]   <= wdata_i;
                default: ;
            endcase
        end
    end

    // Summary path
    logic [NUM_SRC-1:0] src_ind;
    logic               swi_latch;
    logic               sum_rd;
    sum_reg_t           summary;

    assign sum_rd = rd_en_i && (addr_e == ADDR_SUM);

    alarm_src_summary #(.ALM_PER_SRC(ALM_PER_SRC)) u_summary (
        .alarm_lvl_i (alarm_lvl_i),
        .mask_i      (mask_q[NUM_SRC-1:0]),
        .ind_o       (src_ind)
    );

    alarm_trans_latch u_trans (
        .clk_i      (clk_i),
        .rst_i      (rst_i),
        .pol_i      (pol_q),
        .lvl_i      (trans_lvl_i),
        .arm_i      (mask_q[SUM_SWI_BIT]),
        .rd_clr_i   (sum_rd),
        .hold_clr_i (glb_clr),
        .latch_o    (swi_latch)
    );

    always_comb begin
        summary      = '0;
        summary.swi  = swi_latch & mask_q[SUM_SWI_BIT];
        summary.rsvd = 1'b0;
        summary.src  = src_ind;
    end

    // Read mux
    logic [REG_W-1:0] rd_mux;
    logic [REG_W-1:0] cmd_view;

    always_comb begin
        cmd_view = '0;
        for (int c = 0; c < NUM_RST_CH; c++) begin
            cmd_view[cmd_bit(c)] = rst_busy[c];
        end
    end

    always_comb begin
        case (addr_e)
            ADDR_SUM:    rd_mux = summary;
            ADDR_MASK:   rd_mux = mask_q;
            ADDR_CMD:    rd_mux = cmd_view;
            ADDR_CTRL:   rd_mux = ctrl_q;
            ADDR_POL_LO: rd_mux = pol_q[REG_W-1:0];
            ADDR_POL_HI: rd_mux = pol_q[POL_W-1:REG_W];
            default:     rd_mux = '0;
        endcase
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            rdata_q    <= '0;
            irq_n_q    <= 1'b1;
            recenter_q <= 1'b0;
        end else begin
            if (rd_en_i) begin
                rdata_q <= rd_mux;
            end
            irq_n_q    <= ~(|summary);
            recenter_q <= rst_start[RST_CH_GLB];
        end
    end

    // Outputs
    assign rdata_o         = rdata_q;
    assign irq_n_o         = irq_n_q;
    assign glb_rst_o       = rst_busy[RST_CH_GLB];
    assign alm_clr_a_o     = rst_busy[RST_CH_A] | rst_busy[RST_CH_GLB];
    assign alm_clr_b_o     = rst_busy[RST_CH_B] | rst_busy[RST_CH_GLB];
    assign fifo_recenter_o = recenter_q;
    assign hiz_a_o         = ctrl_q.hiz_a;
    assign hiz_b_o         = ctrl_q.hiz_b;
    assign ctrl_o          = ctrl_q.gen;

endmodule

// File: rtl/alarm_irq_ctrl_chk.sv
module alarm_irq_ctrl_chk
    import alarm_irq_pkg::*;
#(
    parameter int RST_CYCLES = 8
) (
    input logic              clk_i,
    input logic              rst_i,
    input logic              wr_en_i,
    input logic              rd_en_i,
    input logic [ADDR_W-1:0] addr_i,
    input logic [REG_W-1:0]  wdata_i,
    input logic [REG_W-1:0]  rdata_o,
    input logic              irq_n_o,
    input logic              glb_rst_o,
    input logic              alm_clr_a_o,
    input logic              alm_clr_b_o,
    input logic              fifo_recenter_o
);

    localparam int HC_W = $clog2(RST_CYCLES + 2) + 1;
    logic [HC_W-1:0] glb_hi_cnt;

    always_ff @(posedge clk_i) begin
        if (rst_i || !glb_rst_o) begin
            glb_hi_cnt <= '0;
        end else begin
            glb_hi_cnt <= glb_hi_cnt + 1'b1;
        end
    end

    // R1: the reserved summary bit always reads 0
    assert_sum_rsvd_zero_R1: assert property (@(posedge clk_i) disable iff (rst_i)
        (rd_en_i && addr_i == ADDR_SUM) |=> !rdata_o[SUM_RSVD_BIT]);

    // R6: a global strobe lasts exactly RST_CYCLES clocks
    assert_glb_len_R6: assert property (@(posedge clk_i) disable iff (rst_i)
        $fell(glb_rst_o) |-> (glb_hi_cnt == HC_W'(RST_CYCLES)));

    // R10: a repeated command never stretches the strobe
    assert_no_stretch_R10: assert property (@(posedge clk_i) disable iff (rst_i)
        glb_rst_o |-> (glb_hi_cnt < HC_W'(RST_CYCLES)));

    // R8: an A-side clear without a global reset comes from an A-side command write
    assert_a_clr_src_R8: assert property (@(posedge clk_i) disable iff (rst_i)
        ($rose(alm_clr_a_o) && !glb_rst_o) |->
            $past(wr_en_i && addr_i == ADDR_CMD && wdata_i[cmd_bit(RST_CH_A)]));

    // R8: a global cycle drives both side clears
    assert_glb_both_sides_R8: assert property (@(posedge clk_i) disable iff (rst_i)
        glb_rst_o |-> (alm_clr_a_o && alm_clr_b_o));

    // R7: once a global reset has run for a cycle the interrupt is released
    assert_glb_quiets_irq_R7: assert property (@(posedge clk_i) disable iff (rst_i)
        (glb_rst_o && $past(glb_rst_o)) |-> irq_n_o);

    // R9: the re-center pulse is one cycle wide and sits inside a global cycle
    assert_recenter_single_R9: assert property (@(posedge clk_i) disable iff (rst_i)
        fifo_recenter_o |=> !fifo_recenter_o);

    assert_recenter_in_glb_R9: assert property (@(posedge clk_i) disable iff (rst_i)
        fifo_recenter_o |-> glb_rst_o);

    // R11: reset state of the interrupt and strobes
    assert_reset_state_R11: assert property (@(posedge clk_i)
        rst_i |=> (irq_n_o && !glb_rst_o && !alm_clr_a_o && !alm_clr_b_o && !fifo_recenter_o));

endmodule

bind alarm_irq_ctrl alarm_irq_ctrl_chk #(.RST_CYCLES(RST_CYCLES)) chk_i (
    .clk_i           (clk_i),
    .rst_i           (rst_i),
    .wr_en_i         (wr_en_i),
    .rd_en_i         (rd_en_i),
    .addr_i          (addr_i),
    .wdata_i         (wdata_i),
    .rdata_o         (rdata_o),
    .irq_n_o         (irq_n_o),
    .glb_rst_o       (glb_rst_o),
    .alm_clr_a_o     (alm_clr_a_o),
    .alm_clr_b_o     (alm_clr_b_o),
    .fifo_recenter_o (fifo_recenter_o)
);

// File: tb/alarm_irq_ctrl_tb_top.sv
`timescale 1ns/1ps
module alarm_irq_ctrl_tb_top;
    import alarm_irq_pkg::*;

    localparam int ALM_PER_SRC = 4;
    localparam int ALM_W = NUM_SRC * ALM_PER_SRC;

    logic                  clk_i = 1'b0;
    logic                  rst_i = 1'b1;
    logic                  wr_en_i = 1'b0;
    logic                  rd_en_i = 1'b0;
    logic [ADDR_W-1:0]     addr_i = '0;
    logic [REG_W-1:0]      wdata_i = '0;
    logic [REG_W-1:0]      rdata_o;
    logic [ALM_W-1:0]      alarm_lvl_i = '0;
    logic [NUM_TRANS-1:0]  trans_lvl_i = '0;
    logic                  irq_n_o;
    logic                  glb_rst_o;
    logic                  alm_clr_a_o;
    logic                  alm_clr_b_o;
    logic                  fifo_recenter_o;
    logic                  hiz_a_o;
    logic                  hiz_b_o;
    logic [GEN_CTRL_W-1:0] ctrl_o;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #2 clk_i = ~clk_i;

    alarm_irq_ctrl #(.ALM_PER_SRC(ALM_PER_SRC), .RST_CYCLES(8)) dut_i (.*);

    // {mask, alarm levels, expected summary}
    localparam int NVEC = 8;
    localparam logic [39:0] VEC [NVEC] = '{
        {8'h3F, 24'h000000, 8'h00},
        {8'h3F, 24'h000001, 8'h01},
        {8'h3F, 24'h800000, 8'h20},
        {8'h0F, 24'hF00010, 8'h02},
        {8'h10, 24'h040000, 8'h10},
        {8'h2A, 24'hFFFFFF, 8'h2A},
        {8'h15, 24'h111111, 8'h15},
        {8'h00, 24'hFFFFFF, 8'h00}
    };

    task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %02h expected %02h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk_i);
        wr_en_i = 1'b1; addr_i = a; wdata_i = d;
        @(negedge clk_i);
        wr_en_i = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [7:0] d);
        @(negedge clk_i);
        rd_en_i = 1'b1; addr_i = a;
        @(negedge clk_i);
        rd_en_i = 1'b0;
        d = rdata_o;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk_i);
    endtask

    initial begin
        #(4 * 150000);
        n_fail++;
        $display("FAIL watchdog: run did not finish");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        logic [7:0] d;
        int cnt;

        idle(4);
        rst_i = 1'b0;

        // R11: reset state
        check("R11 irq_n", {7'd0, irq_n_o}, 8'h01);
        check("R11 strobes", {4'd0, glb_rst_o, alm_clr_a_o, alm_clr_b_o, fifo_recenter_o}, 8'h00);
        check("R11 ctrl outs", {hiz_a_o, hiz_b_o, ctrl_o}, 8'h00);
        rd(ADDR_MASK, d);   check("R11 mask", d, 8'h00);
        rd(ADDR_CMD, d);    check("R11 cmd", d, 8'h00);
        rd(ADDR_POL_LO, d); check("R11 pol", d, 8'h00);
        rd(ADDR_SUM, d);    check("R11 summary", d, 8'h00);

        // R1/R5: vector table
        for (int v = 0; v < NVEC; v++) begin
            wr(ADDR_MASK, VEC[v][39:32]);
            alarm_lvl_i = VEC[v][31:8];
            rd(ADDR_SUM, d);
            check($sformatf("R1 vec%0d summary", v), d, VEC[v][7:0]);
            check($sformatf("R5 vec%0d irq_n", v), {7'd0, irq_n_o},
                  {7'd0, (VEC[v][7:0] == 8'h00)});
        end
        alarm_lvl_i = '0;

        // R2: mask readback, bit 6 reads 0
        wr(ADDR_MASK, 8'hFF);
        rd(ADDR_MASK, d); check("R2 mask rsvd", d, 8'hBF);

        // R3/R4/R5: rising edge on line 0
        wr(ADDR_MASK, 8'h80);
        wr(ADDR_POL_LO, 8'h01);
        trans_lvl_i[0] = 1'b1;
        idle(2);
        check("R5 irq on swi", {7'd0, irq_n_o}, 8'h00);
        rd(ADDR_SUM, d); check("R3 rise sets swi", d, 8'h80);
        rd(ADDR_SUM, d); check("R4 read clears", d, 8'h00);
        check("R5 irq released", {7'd0, irq_n_o}, 8'h01);

        // R3: falling edge ignored under rise code; fall code
        trans_lvl_i[0] = 1'b0; idle(2);
        rd(ADDR_SUM, d); check("R3 rise ignores fall", d, 8'h00);
        wr(ADDR_POL_LO, 8'h02);
        trans_lvl_i[0] = 1'b1; idle(2);
        rd(ADDR_SUM, d); check("R3 fall ignores rise", d, 8'h00);
        trans_lvl_i[0] = 1'b0; idle(2);
        rd(ADDR_SUM, d); check("R3 fall sets", d, 8'h80);

        // R3: both edges on line 5 (address 5 bits 3:2)
        wr(ADDR_POL_HI, 8'h0C);
        trans_lvl_i[5] = 1'b1; idle(2);
        rd(ADDR_SUM, d); check("R3 both rise", d, 8'h80);
        trans_lvl_i[5] = 1'b0; idle(2);
        rd(ADDR_SUM, d); check("R3 both fall", d, 8'h80);

        // R3: code 00 on line 1
        trans_lvl_i[1] = 1'b1; idle(2);
        trans_lvl_i[1] = 1'b0; idle(2);
        rd(ADDR_SUM, d); check("R3 off code", d, 8'h00);

        // R3: mask bit 7 clear blocks the latch
        wr(ADDR_POL_LO, 8'h01);
        wr(ADDR_MASK, 8'h00);
        trans_lvl_i[0] = 1'b1; idle(2);
        wr(ADDR_MASK, 8'h80);
        rd(ADDR_SUM, d); check("R3 unarmed no set", d, 8'h00);
        trans_lvl_i[0] = 1'b0; idle(2);

        // R4: event on the read edge wins
        @(negedge clk_i);
        rd_en_i = 1'b1; addr_i = ADDR_SUM; trans_lvl_i[0] = 1'b1;
        @(negedge clk_i);
        rd_en_i = 1'b0;
        check("R4 read data before set", rdata_o, 8'h00);
        rd(ADDR_SUM, d); check("R4 set wins", d, 8'h80);
        trans_lvl_i[0] = 1'b0;

        // R6/R8: A-side cycle length and isolation
        wr(ADDR_CMD, 8'h40);
        check("R8 A only", {5'd0, glb_rst_o, alm_clr_a_o, alm_clr_b_o}, 8'h02);
        cnt = 0;
        for (int i = 0; i < 14; i++) begin
            if (alm_clr_a_o) cnt++;
            @(negedge clk_i);
        end
        check("R6 A length", 8'(cnt), 8'd8);

        // R6/R8: B-side readback
        wr(ADDR_CMD, 8'h20);
        check("R8 B only", {5'd0, glb_rst_o, alm_clr_a_o, alm_clr_b_o}, 8'h01);
        rd(ADDR_CMD, d); check("R6 B reads 1", d, 8'h20);
        idle(10);
        rd(ADDR_CMD, d); check("R6 B self clears", d, 8'h00);

        // R6: unused command bits
        wr(ADDR_CMD, 8'h1F);
        check("R6 unused no strobe", {5'd0, glb_rst_o, alm_clr_a_o, alm_clr_b_o}, 8'h00);
        rd(ADDR_CMD, d); check("R6 unused read 0", d, 8'h00);

        // R10: rewrite during a running cycle
        wr(ADDR_CMD, 8'h40);
        cnt = 0;
        for (int i = 0; i < 14; i++) begin
            if (alm_clr_a_o) cnt++;
            if (i == 2) begin wr_en_i = 1'b1; addr_i = ADDR_CMD; wdata_i = 8'h40; end
            if (i == 3) wr_en_i = 1'b0;
            @(negedge clk_i);
        end
        check("R10 no retrigger", 8'(cnt), 8'd8);

        // R7/R9: global reset
        wr(ADDR_CTRL, 8'hFF);
        check("R7 ctrl outs set", {hiz_a_o, hiz_b_o, ctrl_o}, 8'hFF);
        wr(ADDR_MASK, 8'h3F);
        wr(ADDR_POL_LO, 8'h55);
        alarm_lvl_i = '1;
        wr(ADDR_CMD, 8'h80);
        check("R8 global all", {4'd0, glb_rst_o, alm_clr_a_o, alm_clr_b_o, fifo_recenter_o}, 8'h0F);
        @(negedge clk_i);
        check("R9 pulse one cycle", {7'd0, fifo_recenter_o}, 8'h00);
        wr(ADDR_MASK, 8'h3F);
        rd(ADDR_CMD, d); check("R6 global reads 1", d, 8'h80);
        idle(8);
        check("R6 global ended", {7'd0, glb_rst_o}, 8'h00);
        rd(ADDR_MASK, d);   check("R7 mask cleared, write ignored", d, 8'h00);
        rd(ADDR_CTRL, d);   check("R7 hiz kept", d, 8'hC0);
        rd(ADDR_POL_LO, d); check("R7 pol cleared", d, 8'h00);
        check("R7 irq released", {7'd0, irq_n_o}, 8'h01);
        alarm_lvl_i = '0;

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule